// File: doc/BRIEF.md
# Dword-Window Configuration Address Decoder

This block sits on the host side of an I/O space and turns two 32-bit I/O ports into configuration-space transactions. Software first writes a full dword into the address port. That dword holds an enable flag and a target made of bus, device, function and dword register index. Software then reads or writes the data port, and the block turns that access into one configuration request on its downstream side. It waits for the completion before it lets the I/O cycle finish.

The address port takes only full-dword accesses. Narrower accesses to it are left unclaimed, so another decoder can answer them. Bits that are not stored read back as zero, which lets software tell this mechanism apart from others. With the enable flag clear, the data port answers at once: a read returns all ones and a write is dropped, and no request goes downstream. A read that no downstream device claims also returns all ones.

Top module: `cfg_addr_decoder`

## Requirements
- R1: After reset the address register holds 0, so a full-dword read of the address port (byte address 0xCF8, byte enables 4'b1111) returns 0x00000000.
- R2: A full-dword write to the address port stores bit 31 (enable) and bits 23:2. A read of that port returns the stored value with bits 30:24 and 1:0 forced to zero, so writing 0xFFFFFFFF reads back as 0x80FFFFFC. Such an access claims the I/O cycle (io_hit high) and completes in the same cycle (io_ready high).
- R3: An address-port access whose byte enables are not all set is unclaimed, with io_hit and io_ready low, and it leaves the register unchanged. A dword write of 0xF0000001 followed by a byte write of 0 at 0xCFB (byte enables 4'b1000) reads back as 0x80000000.
- R4: While bit 31 is clear, a data-port access (dword address 0xCFC, any non-zero byte enables) raises no cfg_req and completes in its first cycle. A read returns 0xFFFFFFFF and a write is dropped.
- R5: While bit 31 is set, a data-port access issues a request with the fields taken from the address register: cfg_bus from bits 23:16, cfg_dev from bits 15:11, cfg_fn from bits 10:8 and cfg_reg from bits 7:2. Device 31 and function 7 can be reached.
- R6: A request raises cfg_req in the cycle after the access is first seen and holds it until cfg_done. io_ready stays low until the cycle in which cfg_done is high. cfg_we follows io_wr, and cfg_be and cfg_wdata pass io_be and io_wdata through unchanged.
- R7: At completion, a read returns cfg_rdata when cfg_claimed is high and 0xFFFFFFFF when it is low.
- R8: An access to any other I/O dword is unclaimed, with io_hit and io_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O byte address |
| io_be | input | 4 | I/O byte enables |
| io_rd | input | 1 | Read strobe, held until io_ready |
| io_wr | input | 1 | Write strobe, held until io_ready |
| io_wdata | input | 32 | I/O write data |
| io_rdata | output | 32 | I/O read data, valid with io_ready |
| io_ready | output | 1 | Access completes this cycle |
| io_hit | output | 1 | Access is claimed by this block |
| cfg_req | output | 1 | Configuration request pending |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_fn | output | 3 | Target function |
| cfg_reg | output | 6 | Target dword register index |
| cfg_be | output | 4 | Request byte enables |
| cfg_wdata | output | 32 | Request write data |
| cfg_done | input | 1 | Completion strobe |
| cfg_claimed | input | 1 | A device claimed the request |
| cfg_rdata | input | 32 | Completion read data |

## Verification
The bench builds the block with its default port parameters, the address port at 0xCF8 and the data window at 0xCFC. With these, the bench can run the mechanism-probe sequences software uses: the all-ones write read back with reserved bits zero, and the byte write to 0xCFB that must not disturb the register. The bench's downstream responder delays each completion by several cycles and chooses per request whether the request is claimed. This exercises both the wait path and the all-ones fill for unclaimed reads, and it reaches the highest device and function numbers.

// File: rtl/cfg_dec_pkg.sv
// Package: shared types and bit positions for the configuration address decoder.
// Assumes a 32-bit address register whose field layout is fixed by software.
package cfg_dec_pkg;

    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int FN_W    = 3;
    localparam int REG_W   = 6;
    localparam int EN_POS  = 31;
    localparam int BUS_LSB = 16;
    localparam int DEV_LSB = 11;
    localparam int FN_LSB  = 8;
    localparam int REG_LSB = 2;

    typedef struct packed {
        logic             en;
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [REG_W-1:0] reg_idx;
    } cfg_target_t;

    // Unpack a written dword into the stored target fields.
    function automatic cfg_target_t unpack_target(input logic [DATA_W-1:0] d);
        cfg_target_t t;
        t.en      = d[EN_POS];
        t.bus     = d[BUS_LSB +: BUS_W];
        t.dev     = d[DEV_LSB +: DEV_W];
        t.fn      = d[FN_LSB  +: FN_W];
        t.reg_idx = d[REG_LSB +: REG_W];
        return t;
    endfunction

    // Rebuild the readback dword, reserved bits zero.
    function automatic logic [DATA_W-1:0] pack_target(input cfg_target_t t);
        logic [DATA_W-1:0] d;
        d = '0;
        d[EN_POS]             = t.en;
        d[BUS_LSB +: BUS_W]   = t.bus;
        d[DEV_LSB +: DEV_W]   = t.dev;
        d[FN_LSB  +: FN_W]    = t.fn;
        d[REG_LSB +: REG_W]   = t.reg_idx;
        return d;
    endfunction

endpackage

// File: rtl/cfg_addr_store.sv
// Module: holds the configuration address register.
// What it does: captures a full-dword write and presents the stored fields
// together with the readback dword, in which the reserved bits are zero.
// Assumes: wr_en is already qualified as a full-dword address-port write.
module cfg_addr_store
    import cfg_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output cfg_target_t       target,
    output logic [DATA_W-1:0] rdback
);

    cfg_target_t tgt_q;

    // Store the target fields on a qualified write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else if (wr_en) begin
            tgt_q <= unpack_target(wdata);
        end
    end

    // Present the fields and the readback dword.
    always_comb begin
        target = tgt_q;
        rdback = pack_target(tgt_q);
    end

endmodule

// File: rtl/cfg_port_decode.sv
// Module: I/O port decoder.
// What it does: recognises, per cycle, a strobed access to the address port
// (full dword only) or to the data window (any non-zero byte enables).
// Assumes: io_addr is a byte address and both ports are dword aligned.
module cfg_port_decode
    import cfg_dec_pkg::*;
#(
    parameter logic [15:0] ADDR_PORT = 16'hCF8,
    parameter logic [15:0] DATA_PORT = 16'hCFC
)(
    input  logic [15:0]     io_addr,
    input  logic [BE_W-1:0] io_be,
    input  logic            io_rd,
    input  logic            io_wr,
    output logic            addr_sel,
    output logic            data_sel
);

    localparam logic [13:0] ADDR_DW = ADDR_PORT[15:2];
    localparam logic [13:0] DATA_DW = DATA_PORT[15:2];

    // Match the dword address, byte enables and strobe for each port.
    always_comb begin
        addr_sel = (io_rd || io_wr) && (io_addr[15:2] == ADDR_DW) && (&io_be);
        data_sel = (io_rd || io_wr) && (io_addr[15:2] == DATA_DW) && (|io_be);
    end

endmodule

// File: rtl/cfg_xfer_ctl.sv
// Module: request sequencer.
// What it does: enters the busy state when an enabled data access begins
// and leaves it on the completion strobe.
// Assumes: the I/O master holds its strobe until io_ready.
module cfg_xfer_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    output logic busy
);

    typedef enum logic {ST_IDLE, ST_BUSY} xfer_st_t;
    xfer_st_t st_q;

    // Move between idle and busy on start and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: if (start) st_q <= ST_BUSY;
                ST_BUSY: if (done)  st_q <= ST_IDLE;
                default:            st_q <= ST_IDLE;
            endcase
        end
    end

    // Expose the busy flag.
    always_comb busy = (st_q == ST_BUSY);

endmodule

// File: rtl/cfg_addr_decoder.sv
// Module: configuration address decoder (top).
// What it does: pairs an address register port with a data window port,
// and turns enabled data-window accesses into downstream configuration
// requests. Disabled or unclaimed reads return all ones.
// Assumes: one I/O access at a time, strobes held until io_ready.
module cfg_addr_decoder
    import cfg_dec_pkg::*;
#(
    parameter logic [15:0] ADDR_PORT = 16'hCF8,
    parameter logic [15:0] DATA_PORT = 16'hCFC
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       io_addr,
    input  logic [BE_W-1:0]   io_be,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_ready,
    output logic              io_hit,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [BUS_W-1:0]  cfg_bus,
    output logic [DEV_W-1:0]  cfg_dev,
    output logic [FN_W-1:0]   cfg_fn,
    output logic [REG_W-1:0]  cfg_reg,
    output logic [BE_W-1:0]   cfg_be,
    output logic [DATA_W-1:0] cfg_wdata,
    input  logic              cfg_done,
    input  logic              cfg_claimed,
    input  logic [DATA_W-1:0] cfg_rdata
);

    logic              addr_sel;
    logic              data_sel;
    logic              busy;
    logic              start;
    cfg_target_t       target;
    logic [DATA_W-1:0] rdback;

    cfg_port_decode #(
        .ADDR_PORT (ADDR_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_dec (
        .io_addr  (io_addr),
        .io_be    (io_be),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .addr_sel (addr_sel),
        .data_sel (data_sel)
    );

    cfg_addr_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (addr_sel && io_wr),
        .wdata  (io_wdata),
        .target (target),
        .rdback (rdback)
    );

    cfg_xfer_ctl u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .done  (cfg_done),
        .busy  (busy)
    );

    // Start a request only for an enabled data access while idle.
    always_comb start = data_sel && target.en && !busy;

    // I/O side: claim, completion and read data.
    always_comb begin
        io_hit   = addr_sel || data_sel;
        io_ready = addr_sel || (data_sel && !target.en) || (data_sel && busy && cfg_done);
        if (addr_sel) begin
            io_rdata = rdback;
        end else if (busy && cfg_claimed) begin
            io_rdata = cfg_rdata;
        end else begin
            io_rdata = '1;
        end
    end

    // Downstream side: fields from the register, data and enables passed through.
    always_comb begin
        cfg_req   = busy;
        cfg_we    = io_wr;
        cfg_bus   = target.bus;
        cfg_dev   = target.dev;
        cfg_fn    = target.fn;
        cfg_reg   = target.reg_idx;
        cfg_be    = io_be;
        cfg_wdata = io_wdata;
    end

endmodule

// File: rtl/cfg_addr_decoder_chk.sv
// Module: assertion checker for the configuration address decoder.
// What it does: checks reserved-bit readback, request gating, the wait
// handshake and the unclaimed fill; bound into the top below.
// Assumes: it is attached to cfg_addr_decoder by the bind that follows.
module cfg_addr_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_rd,
    input logic        io_ready,
    input logic        io_hit,
    input logic [31:0] io_rdata,
    input logic        cfg_req,
    input logic        cfg_done,
    input logic        cfg_claimed,
    input logic        addr_sel,
    input logic        data_sel,
    input logic [31:0] rdback
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (io_ready && io_rd && addr_sel) |-> (io_rdata[30:24] == 7'd0 && io_rdata[1:0] == 2'd0)); // R2

    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_req) |-> rdback[31]); // R4

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_done) |=> cfg_req); // R6

    AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (data_sel && rdback[31] && !cfg_done) |-> !io_ready); // R6

    AST_UNCLAIMED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (io_ready && io_rd && cfg_req && cfg_done && !cfg_claimed) |-> (io_rdata == 32'hFFFF_FFFF)); // R7

    AST_NO_HIT_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !io_hit |-> !io_ready); // R8

endmodule

bind cfg_addr_decoder cfg_addr_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_rd       (io_rd),
    .io_ready    (io_ready),
    .io_hit      (io_hit),
    .io_rdata    (io_rdata),
    .cfg_req     (cfg_req),
    .cfg_done    (cfg_done),
    .cfg_claimed (cfg_claimed),
    .addr_sel    (addr_sel),
    .data_sel    (data_sel),
    .rdback      (rdback)
);

// File: tb/sim_cfg_addr_decoder.sv
// Bench: scoreboard for the configuration address decoder.
// Driver tasks push expected read data and expected requests into queues;
// a read monitor and a downstream responder pop and compare them.
module sim_cfg_addr_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_ready;
    logic        io_hit;
    logic        cfg_req;
    logic        cfg_we;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [5:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_done = 1'b0;
    logic        cfg_claimed = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int n_reqs  = 0;
    int cycles  = 0;

    typedef struct {
        logic        we;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [5:0]  rg;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic        claim;
        logic [31:0] rdata;
        int          lat;
    } req_item_t;

    logic [31:0] exp_rd_val[$];
    string       exp_rd_tag[$];
    req_item_t   exp_req[$];

    always #10 clk = ~clk;

    cfg_addr_decoder u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_be(io_be),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_ready(io_ready), .io_hit(io_hit), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn), .cfg_reg(cfg_reg),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_done(cfg_done),
        .cfg_claimed(cfg_claimed), .cfg_rdata(cfg_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: compare completed reads with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && io_rd && io_ready) begin
            if (exp_rd_val.size() == 0) begin
                check(1'b0, "unexpected read", io_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_rd_val.pop_front();
                t = exp_rd_tag.pop_front();
                check(io_rdata === e, t, io_rdata, e);
            end
        end
    end

    // Responder: check each request against the scoreboard and complete it.
    initial begin
        int cnt;
        req_item_t it;
        cnt = 0;
        forever begin
            @(posedge clk);
            #2;
            if (cfg_done) begin
                cfg_done = 1'b0;
                cnt = 0;
            end else if (cfg_req) begin
                if (cnt == 0) begin
                    n_reqs++;
                    if (exp_req.size() == 0) begin
                        check(1'b0, "R4 unexpected request", {27'd0, cfg_dev}, 32'h0);
                        it.lat = 0; it.claim = 1'b0; it.rdata = '0;
                    end else begin
                        it = exp_req.pop_front();
                        check({cfg_bus, cfg_dev, cfg_fn, cfg_reg} === {it.bus, it.dev, it.fn, it.rg},
                              "R5 request fields", {10'd0, cfg_bus, cfg_dev, cfg_fn, cfg_reg},
                              {10'd0, it.bus, it.dev, it.fn, it.rg});
                        check({cfg_we, cfg_be} === {it.we, it.be}, "R6 direction/byte enables",
                              {27'd0, cfg_we, cfg_be}, {27'd0, it.we, it.be});
                        if (it.we) check(cfg_wdata === it.wdata, "R6 write data", cfg_wdata, it.wdata);
                    end
                end
                if (cnt >= it.lat) begin
                    cfg_claimed = it.claim;
                    cfg_rdata   = it.rdata;
                    cfg_done    = 1'b1;
                end
                cnt++;
            end
        end
    end

    // Claimed access: hold strobe until io_ready, optionally checking for a wait.
    task automatic io_access(input bit wr, input logic [15:0] a, input logic [3:0] be,
                             input logic [31:0] d, input bit expect_wait, input string tag);
        int waited;
        waited = 0;
        @(posedge clk);
        #2;
        io_addr = a; io_be = be; io_wdata = d; io_wr = wr; io_rd = !wr;
        forever begin
            @(negedge clk);
            if (io_ready) break;
            waited++;
            if (!cfg_req && waited > 1) begin
                check(1'b0, {tag, " no completion path"}, 32'(waited), 32'h0);
                break;
            end
        end
        check(expect_wait ? (waited > 0) : (waited == 0), {tag, " wait cycles"}, 32'(waited),
              expect_wait ? 32'h1 : 32'h0);
        @(posedge clk);
        #2;
        io_rd = 1'b0; io_wr = 1'b0; io_be = '0;
    endtask

    task automatic io_read_exp(input logic [15:0] a, input logic [3:0] be, input logic [31:0] e,
                               input bit expect_wait, input string tag);
        exp_rd_val.push_back(e);
        exp_rd_tag.push_back(tag);
        io_access(1'b0, a, be, '0, expect_wait, tag);
    endtask

    // Unclaimed access: one cycle, io_hit and io_ready must stay low.
    task automatic io_unclaimed(input bit wr, input logic [15:0] a, input logic [3:0] be,
                                input logic [31:0] d, input string tag);
        @(posedge clk);
        #2;
        io_addr = a; io_be = be; io_wdata = d; io_wr = wr; io_rd = !wr;
        @(negedge clk);
        check(!io_hit && !io_ready, tag, {30'd0, io_hit, io_ready}, 32'h0);
        @(posedge clk);
        #2;
        io_rd = 1'b0; io_wr = 1'b0; io_be = '0;
    endtask

    task automatic push_req(input logic we, input logic [31:0] areg, input logic [3:0] be,
                            input logic [31:0] wd, input logic claim, input logic [31:0] rd, input int lat);
        req_item_t it;
        it.we = we; it.bus = areg[23:16]; it.dev = areg[15:11]; it.fn = areg[10:8];
        it.rg = areg[7:2]; it.be = be; it.wdata = wd; it.claim = claim; it.rdata = rd; it.lat = lat;
        exp_req.push_back(it);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int r0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset value
        io_read_exp(16'hCF8, 4'hF, 32'h0000_0000, 1'b0, "R1 reset readback");

        // R2: all-ones write reads back with reserved bits zero
        io_access(1'b1, 16'hCF8, 4'hF, 32'hFFFF_FFFF, 1'b0, "R2 write");
        io_read_exp(16'hCF8, 4'hF, 32'h80FF_FFFC, 1'b0, "R2 readback");

        // R3: byte write at 0xCFB is not captured
        io_access(1'b1, 16'hCF8, 4'hF, 32'hF000_0001, 1'b0, "R3 dword write");
        io_unclaimed(1'b1, 16'hCFB, 4'b1000, 32'h0000_0000, "R3 byte write unclaimed");
        io_unclaimed(1'b0, 16'hCF8, 4'b0011, 32'h0, "R3 word read unclaimed");
        io_read_exp(16'hCF8, 4'hF, 32'h8000_0000, 1'b0, "R3 readback");

        // R4: enable clear, no request
        io_access(1'b1, 16'hCF8, 4'hF, 32'h0000_0000, 1'b0, "R4 clear");
        r0 = n_reqs;
        io_read_exp(16'hCFC, 4'hF, 32'hFFFF_FFFF, 1'b0, "R4 disabled read");
        io_access(1'b1, 16'hCFC, 4'hF, 32'h1234_5678, 1'b0, "R4 disabled write");
        repeat (2) @(negedge clk);
        check(n_reqs == r0, "R4 request count", 32'(n_reqs), 32'(r0));

        // R5/R6/R7: claimed read with latency
        io_access(1'b1, 16'hCF8, 4'hF, 32'h8012_3A44, 1'b0, "R5 target write");
        push_req(1'b0, 32'h8012_3A44, 4'hF, '0, 1'b1, 32'hDEAD_BEEF, 3);
        io_read_exp(16'hCFC, 4'hF, 32'hDEAD_BEEF, 1'b1, "R7 claimed read");

        // R5/R6: highest device/function, partial write
        io_access(1'b1, 16'hCF8, 4'hF, 32'hFFFF_FFFF, 1'b0, "R5 max target");
        push_req(1'b1, 32'h80FF_FFFC, 4'b0101, 32'hA5C3_0F96, 1'b1, '0, 2);
        io_access(1'b1, 16'hCFC, 4'b0101, 32'hA5C3_0F96, 1'b1, "R6 write");

        // R7: unclaimed read returns all ones
        push_req(1'b0, 32'h80FF_FFFC, 4'hF, '0, 1'b0, 32'h1111_2222, 4);
        io_read_exp(16'hCFC, 4'hF, 32'hFFFF_FFFF, 1'b1, "R7 unclaimed read");

        // R6: byte read at 0xCFE forwards its byte enables
        push_req(1'b0, 32'h80FF_FFFC, 4'b0100, '0, 1'b1, 32'h00AB_0000, 1);
        io_read_exp(16'hCFE, 4'b0100, 32'h00AB_0000, 1'b1, "R6 byte read");

        // R8: other ports are unclaimed
        io_unclaimed(1'b0, 16'h0080, 4'hF, 32'h0, "R8 other read");
        io_unclaimed(1'b1, 16'hCF4, 4'hF, 32'h0, "R8 other write");

        repeat (4) @(negedge clk);
        check(exp_req.size() == 0 && exp_rd_val.size() == 0, "R6 scoreboard drained",
              32'(exp_req.size() + exp_rd_val.size()), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule